// File: doc/BRIEF.md
# Indexed RTC periodic interrupt unit

This block is a small clock-chip style peripheral that software reaches through two byte-wide ports. A byte written to the index port names one of the internal registers, and the data port then reads or writes that register. The top bit of every index byte is a mask flag for the non-maskable interrupt line, and the block exports it as a plain output.

Inside sit two control registers and a status register. A free-running divider is advanced by a 32.768 kHz time-base strobe. It produces periodic events whose rate comes from a four-bit field in control register A, but only while a three-bit divider-select field above it holds the running code. An enable bit in control register B gates the interrupt output. Status register C latches the periodic flag and a summary interrupt flag. Reading C returns both and clears them. An event that lands in the same cycle as that read is kept back and posted just after it.

Top module: `rtc_periodic_irq`

## Requirements
- R1: Access is two-step. A write on port 0 (bus_addr=0) stores the index, and a read or write on port 1 then reaches the register it names: A at index 0x0A, B at 0x0B, C at 0x0C. After reset A reads 0x26, B reads 0x00, C reads 0x00, and irq and nmi_mask are low.
- R2: Bit 7 of the index byte drives nmi_mask and bits 6:0 select the register. Reading port 0 returns the last index byte, including bit 7.
- R3: Bits 3:0 of A set the rate. Rate 0 gives no events. Rate r from 3 to 15 gives one event every 2^(r-1) time-base strobes. Rates 1 and 2 behave like rates 8 and 9, giving periods of 128 and 256 strobes.
- R4: The divider runs only while bits 6:4 of A equal 3'b010. With any other code the count is held at zero and no events occur. Every write to A restarts the count, so the first event comes on the 2^(r-1)-th strobe after the write.
- R5: Bit 6 of B enables the interrupt. All eight bits of B read back as written. The periodic flag (bit 6 of C) is set on every event whether or not the enable bit is set.
- R6: A read of C returns {bit7 = flag AND enable, bit6 = flag, bits 5:0 = 0} and clears the flag.
- R7: An event in the same cycle as a read of C does not show in that read. It is held and sets the flag on the following cycle.
- R8: irq is high exactly while the flag and the enable bit are both set. It stays high across further events until C is read. Clearing the enable bit drops irq and leaves the flag set.
- R9: Bit 7 of A reads 0 and ignores writes. Writes to C and to unmapped indices change nothing, and unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| bus_addr | input | 1 | Port select: 0 = index, 1 = data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| nmi_mask | output | 1 | NMI mask flag from the last index byte |
| irq | output | 1 | Level interrupt request |

## Verification
A divider count that drifts shows up as the flag appearing one or more strobes early or late. The bench reads C on the strobe just before the expected event and again on the event strobe, so such an error is caught within one period. A flag that is cleared wrongly, or an event lost on a read, shows as a wrong C value or as irq failing to rise on the cycle after the read. A wrong enable or mask path shows at irq or nmi_mask one clock after the write that should have changed it.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

  localparam logic [6:0] IDX_CTRL_A = 7'h0A;
  localparam logic [6:0] IDX_CTRL_B = 7'h0B;
  localparam logic [6:0] IDX_STAT_C = 7'h0C;

  localparam int B_PIE_BIT  = 6;
  localparam int C_PF_BIT   = 6;
  localparam int C_IRQF_BIT = 7;

  localparam logic [6:0] A_RESET = 7'h26;
  localparam logic [2:0] DVS_RUN = 3'b010;

  typedef struct packed {
    logic [2:0] dvs;
    logic [3:0] rate;
    logic       pie;
    logic       a_written;
  } rtcp_ctl_t;

endpackage

// File: rtl/rtcp_regfile.sv
module rtcp_regfile
  import rtcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  input  logic [7:0] stat_byte,
  output logic [7:0] bus_rdata,
  output logic       nmi_mask,
  output logic       stat_read,
  output rtcp_ctl_t  ctl
);

  logic [6:0] idx_q, idx_d;
  logic       nmi_q, nmi_d;
  logic [6:0] a_q, a_d;
  logic [7:0] b_q, b_d;
  logic       idx_we, data_we;
  logic       a_we, b_we;

  assign idx_we  = bus_wr && !bus_addr;
  assign data_we = bus_wr &&  bus_addr;
  assign a_we    = data_we && (idx_q == IDX_CTRL_A);
  assign b_we    = data_we && (idx_q == IDX_CTRL_B);

  always_comb begin
    idx_d = idx_q;
    nmi_d = nmi_q;
    a_d   = a_q;
    b_d   = b_q;
    if (idx_we) begin
      idx_d = bus_wdata[6:0];
      nmi_d = bus_wdata[7];
    end
    if (a_we) a_d = bus_wdata[6:0];
    if (b_we) b_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      nmi_q <= 1'b0;
      a_q   <= A_RESET;
      b_q   <= '0;
    end else begin
      idx_q <= idx_d;
      nmi_q <= nmi_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (!bus_addr) begin
      bus_rdata = {nmi_q, idx_q};
    end else begin
      case (idx_q)
        IDX_CTRL_A: bus_rdata = {1'b0, a_q};
        IDX_CTRL_B: bus_rdata = b_q;
        IDX_STAT_C: bus_rdata = stat_byte;
        default:    bus_rdata = 8'h00;
      endcase
    end
  end

  assign stat_read     = bus_rd && bus_addr && (idx_q == IDX_STAT_C);
  assign nmi_mask      = nmi_q;
  assign ctl.dvs       = a_q[6:4];
  assign ctl.rate      = a_q[3:0];
  assign ctl.pie       = b_q[B_PIE_BIT];
  assign ctl.a_written = a_we;

  AST_NMI_FOLLOWS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> (nmi_mask == $past(bus_wdata[7]))); // R2

  AST_B_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr) |=> $stable(ctl.pie)); // R5

endmodule

// File: rtl/rtcp_rate_div.sv
module rtcp_rate_div
  import rtcp_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] rate,
  input  logic [2:0] dvs,
  input  logic       restart,
  output logic       evt
);

  localparam int SHW = $clog2(PRESC_W);

  logic [PRESC_W-1:0] cnt_q, cnt_d;
  logic [PRESC_W-1:0] mask;
  logic [SHW-1:0]     shamt;
  logic               run;

  assign run = (dvs == DVS_RUN);

  // period 2^shamt strobes; the two lowest nonzero codes alias slow rates
  always_comb begin
    case (rate)
      4'd1:    shamt = SHW'(7);
      4'd2:    shamt = SHW'(8);
      default: shamt = SHW'(rate - 4'd1);
    endcase
    mask = (PRESC_W'(1) << shamt) - PRESC_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) cnt_d = '0;
    else if (tick)       cnt_d = cnt_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign evt = tick && run && !restart && (rate != 4'd0) &&
               ((cnt_q & mask) == mask);

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && run) |=> $stable(cnt_q)); // R3

  AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/rtcp_flag_ctl.sv
module rtcp_flag_ctl
  import rtcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       stat_read,
  input  logic       pie,
  output logic [7:0] stat_byte,
  output logic       irq
);

  logic pf_q, pf_d;
  logic held_q, held_d;

  always_comb begin
    pf_d   = pf_q;
    held_d = 1'b0;
    if (stat_read) begin
      pf_d   = 1'b0;
      held_d = evt || held_q;
    end else begin
      pf_d   = pf_q || evt || held_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q   <= 1'b0;
      held_q <= 1'b0;
    end else begin
      pf_q   <= pf_d;
      held_q <= held_d;
    end
  end

  always_comb begin
    stat_byte             = 8'h00;
    stat_byte[C_PF_BIT]   = pf_q;
    stat_byte[C_IRQF_BIT] = pf_q && pie;
  end

  assign irq = pf_q && pie;

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !stat_read) |=> pf_q); // R5

  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stat_read |=> !pf_q); // R6

  AST_HELD_EVENT_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && evt) ##1 !stat_read |=> pf_q); // R7

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_q) |-> ($past(evt) || $past(held_q))); // R8

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtcp_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       nmi_mask,
  output logic       irq
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  rtcp_ctl_t  ctl;
  logic [7:0] stat_byte;
  logic       stat_read;
  logic       evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rtcp_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .stat_byte (stat_byte),
    .bus_rdata (bus_rdata),
    .nmi_mask  (nmi_mask),
    .stat_read (stat_read),
    .ctl       (ctl)
  );

  rtcp_rate_div #(.PRESC_W(PRESC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick_32k),
    .rate    (ctl.rate),
    .dvs     (ctl.dvs),
    .restart (ctl.a_written),
    .evt     (evt)
  );

  rtcp_flag_ctl u_flags (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .evt       (evt),
    .stat_read (stat_read),
    .pie       (ctl.pie),
    .stat_byte (stat_byte),
    .irq       (irq)
  );

endmodule

// File: tb/tb_rtc_periodic_irq.sv
`timescale 1ns/1ps
module tb_rtc_periodic_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       nmi_mask;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtc_periodic_irq dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nmi_mask(nmi_mask), .irq(irq)
  );

  // monitor: compare every read against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL read with no expectation: actual %02h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic port_wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic port_rd(input logic a, input logic [7:0] e, input string t,
                         input logic with_tick);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1; tick_32k = with_tick;
    step();
    bus_rd = 1'b0; tick_32k = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    port_wr(1'b0, idx);
    port_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, input logic [7:0] e, input string t);
    port_wr(1'b0, idx);
    port_rd(1'b1, e, t, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_32k = 1'b1; step();
      tick_32k = 1'b0; step();
    end
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    @(negedge clk);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
    step();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state and two-step access
    chk(irq, 1'b0, "R1 irq after reset");
    chk(nmi_mask, 1'b0, "R1 nmi after reset");
    reg_rd(8'h0A, 8'h26, "R1 A reset");
    reg_rd(8'h0B, 8'h00, "R1 B reset");
    reg_rd(8'h0C, 8'h00, "R1 C reset");

    // R2 nmi bit in index byte
    port_wr(1'b0, 8'h8A);
    chk(nmi_mask, 1'b1, "R2 nmi set");
    port_rd(1'b0, 8'h8A, "R2 index readback", 1'b0);
    port_rd(1'b1, 8'h26, "R2 low bits select A", 1'b0);
    port_wr(1'b0, 8'h0B);
    chk(nmi_mask, 1'b0, "R2 nmi clear");

    // R9 read-only and ignored writes
    reg_wr(8'h0A, 8'hA3);
    reg_rd(8'h0A, 8'h23, "R9 A bit7 reads 0");
    reg_wr(8'h20, 8'h55);
    reg_rd(8'h20, 8'h00, "R9 unmapped reads 0");
    reg_wr(8'h0C, 8'hFF);
    reg_rd(8'h0C, 8'h00, "R9 C write ignored");

    // R5 flag sets without enable; rate 3 period 4 (R3)
    reg_wr(8'h0A, 8'h23);
    ticks(3);
    reg_rd(8'h0C, 8'h00, "R3 no flag before 4th strobe");
    ticks(1);
    chk(irq, 1'b0, "R5 irq gated by enable");
    reg_rd(8'h0C, 8'h40, "R5 flag without enable");

    // R8 level irq, enable gating
    reg_wr(8'h0B, 8'h47);
    reg_wr(8'h0A, 8'h23);
    ticks(4);
    chk(irq, 1'b1, "R8 irq rises");
    ticks(4);
    chk(irq, 1'b1, "R8 irq held across events");
    reg_wr(8'h0B, 8'h07);
    chk(irq, 1'b0, "R8 enable clear drops irq");
    reg_rd(8'h0B, 8'h07, "R5 B other bits kept");
    reg_rd(8'h0C, 8'h40, "R8 flag kept after disable");
    reg_wr(8'h0B, 8'h47);
    ticks(4);
    reg_rd(8'h0C, 8'hC0, "R6 read returns both flags");
    chk(irq, 1'b0, "R6 read clears irq");

    // R7 event during read is held
    port_wr(1'b0, 8'h0C);
    ticks(3);
    port_rd(1'b1, 8'h00, "R7 coincident read", 1'b1);
    step();
    chk(irq, 1'b1, "R7 held event posted");
    port_rd(1'b1, 8'hC0, "R7 held flag readable", 1'b0);

    // R3 rate 0 quiet
    reg_wr(8'h0A, 8'h20);
    ticks(40);
    chk(irq, 1'b0, "R3 rate 0 no irq");
    reg_rd(8'h0C, 8'h00, "R3 rate 0 no flag");

    // R4 divider select
    reg_wr(8'h0A, 8'h43);
    ticks(8);
    reg_rd(8'h0C, 8'h00, "R4 divider stopped");
    reg_wr(8'h0A, 8'h24);
    ticks(7);
    reg_rd(8'h0C, 8'h00, "R4 restart rate 4 early");
    ticks(1);
    reg_rd(8'h0C, 8'hC0, "R4 restart rate 4 on time");

    // R3 alias rate 1 -> 128 strobes
    reg_wr(8'h0A, 8'h21);
    ticks(127);
    reg_rd(8'h0C, 8'h00, "R3 rate 1 early");
    ticks(1);
    reg_rd(8'h0C, 8'hC0, "R3 rate 1 on time");

    step();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left: actual %0d expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule